// File: doc/BRIEF.md
# UART Receive Status and Interrupt Qualifier

This block sits behind the bit-level shifter of a UART receiver. Each time the shifter finishes a character it hands over the data bits, the sampled stop bit, the parity bit, a parity-mismatch indication and an address/data marker. The block stores the character in a receive buffer and keeps sticky error flags and an address wake-up flag. It then decides whether the receive interrupt flag is raised for that character.

Two host enables qualify the interrupt. One lets characters that carry errors raise the flag. The other restricts the flag to address characters, which suits multiprocessor links where a node sleeps until it is addressed. A small register port gives the host a status/control byte and the receive buffer. Reading the buffer acknowledges the character: it drops the interrupt and clears all receive flags in one cycle.

Top module: `uart_rx_qual`

## Requirements
- R1: After reset the status byte, the receive buffer and `rx_irq_o` are all 0.
- R2: A character whose stop bit is sampled low sets the framing flag (status bit 7).
- R3: With `par_en_i` = 1, a character with `rx_par_err_i` = 1 sets the parity flag (status bit 6). While `par_en_i` = 0, bit 6 reads 0 and does not count toward the summary bit.
- R4: A character that arrives while the buffer still holds an unread character sets the overrun flag (status bit 5).
- R5: The erroneous-character enable is status bit 3. When it is 0, a character with any error leaves `rx_irq_o` unchanged. When it is 1, such a character raises `rx_irq_o` like a clean one.
- R6: The wake-up enable is status bit 2. When it is 0, every accepted character raises `rx_irq_o`. When it is 1, only address characters do, and an address character with errors still does not raise it if bit 3 is 0.
- R7: Each character is written into the buffer, which is read at `reg_addr_i` = 1 and zero-extended. Status bit 1 takes the character's address marker (1 = address, 0 = data).
- R8: Status bit 0 is the OR of the visible framing, parity, overrun and break flags. A host read at `reg_addr_i` = 1 (with `reg_rd_i` = 1) clears `rx_irq_o`, bits 7..4, bit 1 and therefore bit 0, all in the same cycle.
- R9: A break sets status bit 4 together with bit 7. A break is a frame that is all zeros: the data bits are 0, the stop bit is low, and the parity bit is low when parity is enabled.
- R10: A host write at `reg_addr_i` = 0 loads bits 3 and 2. In bits 7..4 and bit 1, a written 1 leaves the flag unchanged and a written 0 clears it. Written bit 0 is ignored.
- R11: When a buffer read and a new character happen in the same cycle, the flags, the buffer and the interrupt reflect only the new character, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a completed character is presented |
| rx_data_i | input | DATA_W | Received data bits |
| rx_stop_i | input | 1 | Sampled stop bit value |
| rx_par_bit_i | input | 1 | Sampled parity bit value |
| rx_par_err_i | input | 1 | Parity mismatch detected by the shifter |
| rx_addr_i | input | 1 | Character is an address (1) or data (0) |
| par_en_i | input | 1 | Parity checking enabled |
| reg_addr_i | input | 1 | 0 = status/control byte, 1 = receive buffer |
| reg_rd_i | input | 1 | Host read strobe |
| reg_wr_i | input | 1 | Host write strobe |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | RD_W | Read data for the selected register, zero-extended |
| rx_irq_o | output | 1 | Receive interrupt flag |

## Verification
The bench builds the block with the default DATA_W = 8. At this width the read port is a single byte, so status and buffer readbacks compare directly against whole-byte expectations. The all-zero data pattern that a break needs can be driven, and so can a zero-data frame whose parity bit is high, which must not count as a break. Every enable combination, the simultaneous read-and-arrival cycle and the masked parity flag are reached through the normal register port.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned STAT_W = 8;
  // status bit positions (host-visible layout)
  localparam int unsigned B_FE   = 7;
  localparam int unsigned B_PE   = 6;
  localparam int unsigned B_OE   = 5;
  localparam int unsigned B_BRK  = 4;
  localparam int unsigned B_EIE  = 3;
  localparam int unsigned B_WIE  = 2;
  localparam int unsigned B_WAKE = 1;
  localparam int unsigned B_ERR  = 0;
  localparam int unsigned N_ERR  = 4;
  localparam logic SEL_STAT = 1'b0;
  localparam logic SEL_BUF  = 1'b1;

  typedef struct packed {
    logic fe;
    logic pe;
    logic oe;
    logic brk;
  } err_t;
endpackage

// File: rtl/rxq_classify.sv
module rxq_classify
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              par_bit_i,
  input  logic              par_err_i,
  input  logic              par_en_i,
  input  logic              addr_i,
  input  logic              unread_i,
  input  logic              rd_buf_i,
  input  logic              eie_i,
  input  logic              wie_i,
  output err_t              err_o,
  output logic              accept_o
);
  logic any_err;

  always_comb begin
    err_o.fe  = ~stop_i;
    err_o.pe  = par_en_i & par_err_i;
    // overrun only if the old character is not being read this cycle
    err_o.oe  = unread_i & ~rd_buf_i;
    err_o.brk = ~(|data_i) & ~stop_i & ~(par_en_i & par_bit_i);
  end

  assign any_err  = |err_o;
  assign accept_o = (~any_err | eie_i) & (~wie_i | addr_i);
endmodule

// File: rtl/rxq_flag_bank.sv
module rxq_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [N-1:0] wmask_i,
  input  logic         set_i,
  input  logic [N-1:0] set_val_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic nxt;
    always_comb begin
      nxt = q_o[g];
      if (clr_i)     nxt = 1'b0;
      else if (wr_i) nxt = q_o[g] & wmask_i[g];
      if (set_i)     nxt = nxt | set_val_i[g];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[g] <= 1'b0;
      else         q_o[g] <= nxt;
    end
  end
endmodule

// File: rtl/rxq_rxbuf.sv
module rxq_rxbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              unread_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      unread_o <= 1'b0;
    end else begin
      if (load_i) data_o <= data_i;
      if (load_i)    unread_o <= 1'b1;
      else if (rd_i) unread_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_qual.sv
module uart_rx_qual
  import rxq_pkg::*;
#(
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned RD_W   = (DATA_W > STAT_W) ? DATA_W : STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_stop_i,
  input  logic              rx_par_bit_i,
  input  logic              rx_par_err_i,
  input  logic              rx_addr_i,
  input  logic              par_en_i,
  input  logic              reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [RD_W-1:0]   reg_rdata_o,
  output logic              rx_irq_o
);
  logic              rd_buf, wr_stat, unread, accept;
  logic              eie_q, wie_q, wake_q, irq_q;
  logic              pe_vis, rxerr;
  logic [DATA_W-1:0] buf_q;
  logic [STAT_W-1:0] stat;
  err_t              err_q, err_new, err_wmask;
  logic              unused_wbit;

  assign rd_buf      = reg_rd_i & (reg_addr_i == SEL_BUF);
  assign wr_stat     = reg_wr_i & (reg_addr_i == SEL_STAT);
  assign unused_wbit = reg_wdata_i[B_ERR];

  rxq_classify #(.DATA_W(DATA_W)) u_classify (
    .data_i    (rx_data_i),
    .stop_i    (rx_stop_i),
    .par_bit_i (rx_par_bit_i),
    .par_err_i (rx_par_err_i),
    .par_en_i  (par_en_i),
    .addr_i    (rx_addr_i),
    .unread_i  (unread),
    .rd_buf_i  (rd_buf),
    .eie_i     (eie_q),
    .wie_i     (wie_q),
    .err_o     (err_new),
    .accept_o  (accept)
  );

  always_comb begin
    err_wmask.fe  = reg_wdata_i[B_FE];
    err_wmask.pe  = reg_wdata_i[B_PE];
    err_wmask.oe  = reg_wdata_i[B_OE];
    err_wmask.brk = reg_wdata_i[B_BRK];
  end

  rxq_flag_bank #(.N(N_ERR)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rd_buf),
    .wr_i      (wr_stat),
    .wmask_i   (err_wmask),
    .set_i     (rx_valid_i),
    .set_val_i (err_new),
    .q_o       (err_q)
  );

  rxq_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rx_valid_i),
    .data_i   (rx_data_i),
    .rd_i     (rd_buf),
    .data_o   (buf_q),
    .unread_o (unread)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eie_q  <= 1'b0;
      wie_q  <= 1'b0;
      wake_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_stat) begin
        eie_q <= reg_wdata_i[B_EIE];
        wie_q <= reg_wdata_i[B_WIE];
      end
      if (rx_valid_i)   wake_q <= rx_addr_i;
      else if (rd_buf)  wake_q <= 1'b0;
      else if (wr_stat) wake_q <= wake_q & reg_wdata_i[B_WAKE];
      if (rx_valid_i)   irq_q <= (irq_q & ~rd_buf) | accept;
      else if (rd_buf)  irq_q <= 1'b0;
    end
  end

  assign pe_vis = err_q.pe & par_en_i;
  assign rxerr  = err_q.fe | pe_vis | err_q.oe | err_q.brk;

  always_comb begin
    stat         = '0;
    stat[B_FE]   = err_q.fe;
    stat[B_PE]   = pe_vis;
    stat[B_OE]   = err_q.oe;
    stat[B_BRK]  = err_q.brk;
    stat[B_EIE]  = eie_q;
    stat[B_WIE]  = wie_q;
    stat[B_WAKE] = wake_q;
    stat[B_ERR]  = rxerr;
  end

  assign reg_rdata_o = (reg_addr_i == SEL_BUF) ? RD_W'(buf_q) : RD_W'(stat);
  assign rx_irq_o    = irq_q;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic       rx_stop_i,
  input logic       rx_addr_i,
  input logic       rd_buf_i,
  input logic       wr_stat_i,
  input logic       unread_i,
  input logic       eie_i,
  input logic       wie_i,
  input logic [3:0] err_i,   // fe, pe, oe, brk
  input logic       wake_i,
  input logic       irq_i
);
  a_r2_fe_on_low_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !rx_stop_i |=> err_i[3]);

  a_r4_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && unread_i && !rd_buf_i |=> err_i[1]);

  a_r5_err_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !eie_i && !rx_stop_i && !rd_buf_i |=> $stable(irq_i));

  a_r6_data_filtered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && wie_i && !rx_addr_i && !rd_buf_i |=> $stable(irq_i));

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_buf_i && !rx_valid_i |=> (err_i == 4'b0) && !wake_i && !irq_i && !unread_i);

  a_r10_no_set_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && !rx_valid_i && !rd_buf_i |=> ((err_i & ~$past(err_i)) == 4'b0) && !$rose(wake_i));

  a_r11_no_overrun_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rd_buf_i |=> !err_i[1] && unread_i);
endmodule

bind uart_rx_qual rxq_checker u_rxq_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_stop_i  (rx_stop_i),
  .rx_addr_i  (rx_addr_i),
  .rd_buf_i   (rd_buf),
  .wr_stat_i  (wr_stat),
  .unread_i   (unread),
  .eie_i      (eie_q),
  .wie_i      (wie_q),
  .err_i      (err_q),
  .wake_i     (wake_q),
  .irq_i      (irq_q)
);

// File: tb/test_uart_rx_qual.sv
module test_uart_rx_qual;
  localparam int DW = 8;
  localparam logic PK_STAT = 1'b0;
  localparam logic PK_BUF  = 1'b1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_valid, rx_stop, rx_par_bit, rx_par_err, rx_addr, par_en;
  logic [DW-1:0] rx_data;
  logic          reg_addr, reg_rd, reg_wr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic          rx_irq;

  always #5 clk = ~clk;

  uart_rx_qual #(.DATA_W(DW)) i_uart_rx_qual (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_valid_i   (rx_valid),
    .rx_data_i    (rx_data),
    .rx_stop_i    (rx_stop),
    .rx_par_bit_i (rx_par_bit),
    .rx_par_err_i (rx_par_err),
    .rx_addr_i    (rx_addr),
    .par_en_i     (par_en),
    .reg_addr_i   (reg_addr),
    .reg_rd_i     (reg_rd),
    .reg_wr_i     (reg_wr),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .rx_irq_o     (rx_irq)
  );

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  int n_run  = 0;
  int n_fail = 0;

  // reference state, built from the requirements
  logic m_fe, m_pe, m_oe, m_brk, m_eie, m_wie, m_wake, m_irq, m_unread;
  logic [DW-1:0] m_buf;
  logic cur_pen;

  function automatic logic [7:0] m_stat();
    logic pv;
    pv = m_pe & cur_pen;
    return {m_fe, pv, m_oe, m_brk, m_eie, m_wie, m_wake, m_fe | pv | m_oe | m_brk};
  endfunction

  // monitor: pops one expectation per driven cycle
  always @(posedge clk) begin : mon
    exp_t e;
    #3;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_run++;
      if (reg_rdata !== e.rd || rx_irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, reg_rdata, rx_irq, e.rd, e.irq);
      end
    end
  end

  task automatic op(bit v, logic [DW-1:0] d, bit stop, bit pbit, bit perr, bit adr,
                    bit rd, bit wr, logic [7:0] wd, bit peek, string tag);
    logic old_unread, old_eie, old_wie, nfe, npe, noe, nbrk, acc;
    exp_t e;
    @(negedge clk);
    rx_valid = v; rx_data = d; rx_stop = stop; rx_par_bit = pbit;
    rx_par_err = perr; rx_addr = adr; par_en = cur_pen;
    reg_rd = rd; reg_wr = wr; reg_wdata = wd;
    reg_addr = rd ? PK_BUF : PK_STAT;
    old_unread = m_unread; old_eie = m_eie; old_wie = m_wie;
    if (rd) begin
      m_fe = 0; m_pe = 0; m_oe = 0; m_brk = 0; m_wake = 0; m_irq = 0; m_unread = 0;
    end
    if (wr) begin
      m_fe &= wd[7]; m_pe &= wd[6]; m_oe &= wd[5]; m_brk &= wd[4];
      m_eie = wd[3]; m_wie = wd[2]; m_wake &= wd[1];
    end
    if (v) begin
      nfe  = !stop;
      npe  = cur_pen & perr;
      noe  = old_unread & !rd;
      nbrk = (d == '0) && !stop && !(cur_pen && pbit);
      acc  = (!(nfe | npe | noe | nbrk) || old_eie) && (!old_wie || adr);
      m_fe |= nfe; m_pe |= npe; m_oe |= noe; m_brk |= nbrk;
      m_wake = adr; m_buf = d; m_unread = 1; m_irq |= acc;
    end
    e.rd  = (peek == PK_BUF) ? 8'(m_buf) : m_stat();
    e.irq = m_irq;
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    rx_valid = 0; reg_rd = 0; reg_wr = 0; reg_addr = peek;
  endtask

  task automatic rx(logic [DW-1:0] d, bit stop, bit pbit, bit perr, bit adr, bit peek, string tag);
    op(1, d, stop, pbit, perr, adr, 0, 0, 8'h00, peek, tag);
  endtask
  task automatic rdbuf(bit peek, string tag);
    op(0, '0, 1, 0, 0, 0, 1, 0, 8'h00, peek, tag);
  endtask
  task automatic wrstat(logic [7:0] wd, string tag);
    op(0, '0, 1, 0, 0, 0, 0, 1, wd, PK_STAT, tag);
  endtask
  task automatic idle(bit peek, string tag);
    op(0, '0, 1, 0, 0, 0, 0, 0, 8'h00, peek, tag);
  endtask

  task automatic direct(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 0; rx_valid = 0; rx_data = '0; rx_stop = 1; rx_par_bit = 0;
    rx_par_err = 0; rx_addr = 0; par_en = 1; reg_addr = 0; reg_rd = 0;
    reg_wr = 0; reg_wdata = 0;
    cur_pen = 1;
    m_fe = 0; m_pe = 0; m_oe = 0; m_brk = 0; m_eie = 0; m_wie = 0;
    m_wake = 0; m_irq = 0; m_unread = 0; m_buf = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    @(negedge clk);
    reg_addr = PK_STAT; #1;
    direct("R1 status", reg_rdata, 8'h00);
    direct("R1 irq", {7'b0, rx_irq}, 8'h00);
    reg_addr = PK_BUF; #1;
    direct("R1 buffer", reg_rdata, 8'h00);
    reg_addr = PK_STAT;

    // R7 clean data char, R8 read clears
    rx(8'h5A, 1, 0, 0, 0, PK_BUF,  "R7 buffer");
    idle(PK_STAT,                  "R7 status");
    rdbuf(PK_STAT,                 "R8 read clears irq");
    // R2 low stop, R5 rejected with eie=0
    rx(8'h33, 0, 0, 0, 0, PK_STAT, "R2 R5 framing rejected");
    rdbuf(PK_STAT,                 "R8 read clears errors");
    wrstat(8'h08,                  "R10 set eie");
    rx(8'hC3, 0, 0, 0, 0, PK_STAT, "R5 erroneous accepted");
    rdbuf(PK_STAT,                 "R8 clear");
    // R3 parity
    rx(8'h11, 1, 1, 1, 0, PK_STAT, "R3 parity flag");
    cur_pen = 0;
    idle(PK_STAT,                  "R3 parity masked");
    cur_pen = 1;
    rdbuf(PK_STAT,                 "R8 clear");
    // R4 overrun
    rx(8'h01, 1, 0, 0, 0, PK_STAT, "R4 first char");
    rx(8'h02, 1, 0, 0, 0, PK_STAT, "R4 overrun");
    idle(PK_BUF,                   "R7 newest char");
    // R11 read and arrival together
    op(1, 8'h44, 1, 0, 0, 0, 1, 0, 8'h00, PK_STAT, "R11 flags from new char");
    idle(PK_BUF,                   "R11 buffer");
    rdbuf(PK_STAT,                 "R8 clear");
    // R9 break
    rx(8'h00, 0, 0, 0, 0, PK_STAT, "R9 break");
    rdbuf(PK_STAT,                 "R8 clear");
    rx(8'h00, 0, 1, 0, 0, PK_STAT, "R9 parity bit high no break");
    // R10 host writes
    wrstat(8'hFF,                  "R10 ones ignored");
    wrstat(8'h0C,                  "R10 zero clears");
    rdbuf(PK_STAT,                 "R8 clear");
    // R6 wake filtering
    rx(8'h21, 1, 0, 0, 0, PK_STAT, "R6 data filtered");
    rdbuf(PK_STAT,                 "R8 clear");
    rx(8'h80, 1, 0, 0, 1, PK_STAT, "R6 R7 address accepted");
    rdbuf(PK_STAT,                 "R8 clear");
    wrstat(8'h04,                  "R10 wie only");
    rx(8'h90, 0, 0, 0, 1, PK_STAT, "R6 address with error rejected");
    wrstat(8'h00,                  "R10 clear all");

    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule